// File: doc/BRIEF.md
# Accumulator ALU with Flag Register

This block is the arithmetic and logic engine of a small 8-bit processor core. It holds the accumulator and a five-bit flag register (sign, zero, auxiliary carry, parity, carry). On each clock edge where a command is valid, it combines the accumulator with one operand byte and writes the result back. The operand may come from a general register, a memory byte or an immediate field. The surrounding core selects that byte, so immediate forms use the same command codes as the register forms. The block also increments or decrements a byte that belongs to another register and returns the new value on a separate output, updating the flags as it does so.

A purely combinational condition evaluator reads the flag register and answers the branch question for jump, call and return decisions. The answer is available in the same cycle the condition code is presented, and reflects the flags written by the most recent command.

Top module: `accum_alu`

## Requirements
- R1: While `rstN` is low, `accOut`, `regOut` and `flagsOut` are all zero. The first clock edge after release sees this state.
- R2: Code 0 (add) writes A+operand into A, and code 1 (add with carry) writes A+operand+CY into A. Carry becomes the carry out of bit 7 and aux becomes the carry out of bit 3. Add-immediate uses code 0, so no carry input is added.
- R3: Code 2 (subtract) writes A−operand into A, and code 3 (subtract with borrow) writes A−operand−CY into A. Carry becomes 1 when the true difference is negative. Aux becomes 1 when the low-nibble difference is negative. Subtract-immediate-with-borrow uses code 3.
- R4: Codes 4, 5 and 6 write the bitwise AND, OR and XOR of A and the operand into A. Each of them clears carry and aux.
- R5: Code 7 inverts every bit of A and leaves all flags unchanged.
- R6: Code 8 toggles carry and changes nothing else.
- R7: Code 9 increments A and code 10 decrements A. Codes 11 and 12 load the operand plus one or minus one into `regOut` and leave A unchanged. All four set aux from the low-nibble carry (increment) or borrow (decrement), update sign, zero and parity from the new byte, and keep carry unchanged.
- R8: The flag register appears on `flagsOut` with bit 4 = sign, bit 3 = zero, bit 2 = aux, bit 1 = parity, bit 0 = carry. Sign is result bit 7. Zero is set when the result is 00. Parity is 1 when the result holds an even number of ones.
- R9: Code 13 (decimal adjust) first adds 06 if the low nibble of A is above 9 or aux is set. It then adds 60 if the high nibble of that intermediate value is above 9, if it carried out, or if carry is set. Carry becomes 1 exactly when the second correction is applied. After a binary add of two packed-BCD bytes, this gives their packed-BCD sum, with carry showing a sum of 100 or more.
- R10: `condTrue` is 1 for the following codes and states: code 0 always; code 1 when carry is set; code 2 when carry is clear; code 3 when zero is set; code 4 when zero is clear; code 5 when parity is 1; code 6 when parity is 0; code 7 when sign is 0; code 8 when sign is 1. Codes 9 to 15 give 0.
- R11: With `opValid` low, A, `regOut` and flags hold. Code 14 copies the operand into A without touching flags. Code 15 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Command strobe for this cycle |
| opCode | input | 4 | Command code (see requirements) |
| operand | input | 8 | Register, memory or immediate byte |
| condCode | input | 4 | Branch condition selector |
| accOut | output | 8 | Accumulator |
| regOut | output | 8 | Result of the last register increment or decrement |
| flagsOut | output | 5 | Flag register {sign, zero, aux, parity, carry} |
| condTrue | output | 1 | Condition evaluator result |

## Verification
The bench builds the block at its only configuration, an 8-bit data path with 4-bit command and condition codes. At that size, every accumulator value can be swept for every single-operand command. The binary commands can be crossed with a spread of 16 operand values and both carry-in states. The condition evaluator can be checked for all 16 codes across all sign, zero and parity combinations that real results produce, each with carry both clear and set. Decimal adjust is driven with every pair of two-digit BCD operands and compared against decimal arithmetic.

// File: rtl/accum_alu_pkg.sv
package accum_alu_pkg;

  localparam int DATA_W   = 8;
  localparam int NIB_W    = DATA_W / 2;
  localparam int OP_W     = 4;
  localparam int COND_W   = 4;
  localparam int FLAG_W   = 5;
  localparam int BCD_MAX  = 9;
  localparam int BCD_FIX  = 6;

  localparam int FLAG_CY  = 0;
  localparam int FLAG_PAR = 1;
  localparam int FLAG_AUX = 2;
  localparam int FLAG_ZER = 3;
  localparam int FLAG_SGN = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBB  = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_CMA  = 4'd7,
    OP_CMC  = 4'd8,
    OP_INCA = 4'd9,
    OP_DECA = 4'd10,
    OP_INCR = 4'd11,
    OP_DECR = 4'd12,
    OP_DAA  = 4'd13,
    OP_LOAD = 4'd14,
    OP_NOP  = 4'd15
  } aluOp_e;

  typedef enum logic [COND_W-1:0] {
    CC_ALWAYS = 4'd0,
    CC_CARRY  = 4'd1,
    CC_NCARRY = 4'd2,
    CC_ZERO   = 4'd3,
    CC_NZERO  = 4'd4,
    CC_PEVEN  = 4'd5,
    CC_PODD   = 4'd6,
    CC_PLUS   = 4'd7,
    CC_MINUS  = 4'd8
  } condCode_e;

  typedef enum logic [2:0] {
    RES_ADDER,
    RES_LOGIC,
    RES_CMA,
    RES_DAA,
    RES_PASS
  } resSel_e;

  typedef enum logic [1:0] {
    LG_AND,
    LG_OR,
    LG_XOR,
    LG_NONE
  } logicFn_e;

  typedef struct packed {
    logic     accWr;
    logic     regWr;
    resSel_e  resSel;
    logic     subtract;
    logic     carryIn;
    logic     unitStep;
    logic     incOnOperand;
    logic     szpWr;
    logic     auxWr;
    logic     carryWr;
    logic     carryToggle;
    logicFn_e logicFn;
  } aluCtrl_t;

  typedef struct packed {
    logic sign;
    logic zero;
    logic aux;
    logic parity;
    logic carry;
  } aluFlags_t;

endpackage

// File: rtl/accum_alu_ctrl.sv
module accum_alu_ctrl
  import accum_alu_pkg::*;
(
  input  logic            opValid,
  input  logic [OP_W-1:0] opCode,
  output aluCtrl_t        ctrl
);

  always_comb begin
    ctrl         = '0;
    ctrl.resSel  = RES_ADDER;
    ctrl.logicFn = LG_NONE;
    if (opValid) begin
      case (aluOp_e'(opCode))
        OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
          ctrl.resSel   = RES_ADDER;
          ctrl.accWr    = 1'b1;
          ctrl.szpWr    = 1'b1;
          ctrl.auxWr    = 1'b1;
          ctrl.carryWr  = 1'b1;
          ctrl.subtract = (aluOp_e'(opCode) == OP_SUB) || (aluOp_e'(opCode) == OP_SBB);
          ctrl.carryIn  = (aluOp_e'(opCode) == OP_ADC) || (aluOp_e'(opCode) == OP_SBB);
        end
        OP_AND, OP_OR, OP_XOR: begin
          ctrl.resSel  = RES_LOGIC;
          ctrl.accWr   = 1'b1;
          ctrl.szpWr   = 1'b1;
          ctrl.auxWr   = 1'b1;
          ctrl.carryWr = 1'b1;
          case (aluOp_e'(opCode))
            OP_AND:  ctrl.logicFn = LG_AND;
            OP_OR:   ctrl.logicFn = LG_OR;
            default: ctrl.logicFn = LG_XOR;
          endcase
        end
        OP_CMA: begin
          ctrl.resSel = RES_CMA;
          ctrl.accWr  = 1'b1;
        end
        OP_CMC: begin
          ctrl.carryToggle = 1'b1;
        end
        OP_INCA, OP_DECA, OP_INCR, OP_DECR: begin
          ctrl.resSel       = RES_ADDER;
          ctrl.unitStep     = 1'b1;
          ctrl.szpWr        = 1'b1;
          ctrl.auxWr        = 1'b1;
          ctrl.subtract     = (aluOp_e'(opCode) == OP_DECA) || (aluOp_e'(opCode) == OP_DECR);
          ctrl.incOnOperand = (aluOp_e'(opCode) == OP_INCR) || (aluOp_e'(opCode) == OP_DECR);
          ctrl.accWr        = !ctrl.incOnOperand;
          ctrl.regWr        = ctrl.incOnOperand;
        end
        OP_DAA: begin
          ctrl.resSel  = RES_DAA;
          ctrl.accWr   = 1'b1;
          ctrl.szpWr   = 1'b1;
          ctrl.auxWr   = 1'b1;
          ctrl.carryWr = 1'b1;
        end
        OP_LOAD: begin
          ctrl.resSel = RES_PASS;
          ctrl.accWr  = 1'b1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/accum_alu_dp.sv
module accum_alu_dp
  import accum_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  aluCtrl_t          ctrl,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] accQ,
  output logic [DATA_W-1:0] regQ,
  output aluFlags_t         flagsQ
);

  logic [DATA_W-1:0] addA, addB, addBx, addRes;
  logic              addCin, rawCin, addCout;
  logic              adderCarry, adderAux;

  always_comb begin
    addA   = ctrl.incOnOperand ? operand : accQ;
    addB   = ctrl.unitStep ? DATA_W'(1) : operand;
    addCin = ctrl.carryIn & flagsQ.carry;
    addBx  = ctrl.subtract ? ~addB : addB;
    rawCin = ctrl.subtract ? ~addCin : addCin;
    {addCout, addRes} = {1'b0, addA} + {1'b0, addBx} + {{DATA_W{1'b0}}, rawCin};
    adderCarry = ctrl.subtract ? ~addCout : addCout;
    adderAux   = (addA[NIB_W] ^ addBx[NIB_W] ^ addRes[NIB_W]) ^ ctrl.subtract;
  end

  logic [DATA_W-1:0] logicRes;

  always_comb begin
    case (ctrl.logicFn)
      LG_AND:  logicRes = accQ & operand;
      LG_OR:   logicRes = accQ | operand;
      LG_XOR:  logicRes = accQ ^ operand;
      default: logicRes = accQ;
    endcase
  end

  logic              lowFix, hiFix;
  logic [DATA_W:0]   daaLowAdd, daaMid;
  logic [DATA_W-1:0] daaRes;
  logic              daaAux;

  always_comb begin
    lowFix    = (accQ[NIB_W-1:0] > NIB_W'(BCD_MAX)) || flagsQ.aux;
    daaLowAdd = lowFix ? (DATA_W+1)'(BCD_FIX) : '0;
    daaMid    = {1'b0, accQ} + daaLowAdd;
    daaAux    = accQ[NIB_W] ^ daaLowAdd[NIB_W] ^ daaMid[NIB_W];
    hiFix     = (daaMid[DATA_W-1:NIB_W] > NIB_W'(BCD_MAX)) || daaMid[DATA_W] || flagsQ.carry;
    daaRes    = daaMid[DATA_W-1:0] + (hiFix ? DATA_W'(BCD_FIX << NIB_W) : '0);
  end

  logic [DATA_W-1:0] result;
  logic              auxNew, carryNew;

  always_comb begin
    case (ctrl.resSel)
      RES_ADDER: begin result = addRes;   auxNew = adderAux; carryNew = adderCarry; end
      RES_LOGIC: begin result = logicRes; auxNew = 1'b0;     carryNew = 1'b0;       end
      RES_CMA:   begin result = ~accQ;    auxNew = 1'b0;     carryNew = 1'b0;       end
      RES_DAA:   begin result = daaRes;   auxNew = daaAux;   carryNew = hiFix;      end
      default:   begin result = operand;  auxNew = 1'b0;     carryNew = 1'b0;       end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accQ   <= '0;
      regQ   <= '0;
      flagsQ <= '0;
    end else begin
      if (ctrl.accWr) accQ <= result;
      if (ctrl.regWr) regQ <= result;
      if (ctrl.szpWr) begin
        flagsQ.sign   <= result[DATA_W-1];
        flagsQ.zero   <= (result == '0);
        flagsQ.parity <= ~^result;
      end
      if (ctrl.auxWr) flagsQ.aux <= auxNew;
      if (ctrl.carryWr) flagsQ.carry <= carryNew;
      else if (ctrl.carryToggle) flagsQ.carry <= ~flagsQ.carry;
    end
  end

endmodule

// File: rtl/accum_alu_cond.sv
module accum_alu_cond
  import accum_alu_pkg::*;
(
  input  aluFlags_t         flags,
  input  logic [COND_W-1:0] condCode,
  output logic              condTrue
);

  always_comb begin
    case (condCode_e'(condCode))
      CC_ALWAYS: condTrue = 1'b1;
      CC_CARRY:  condTrue = flags.carry;
      CC_NCARRY: condTrue = !flags.carry;
      CC_ZERO:   condTrue = flags.zero;
      CC_NZERO:  condTrue = !flags.zero;
      CC_PEVEN:  condTrue = flags.parity;
      CC_PODD:   condTrue = !flags.parity;
      CC_PLUS:   condTrue = !flags.sign;
      CC_MINUS:  condTrue = flags.sign;
      default:   condTrue = 1'b0;
    endcase
  end

endmodule

// File: rtl/accum_alu.sv
module accum_alu
  import accum_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [OP_W-1:0]   opCode,
  input  logic [DATA_W-1:0] operand,
  input  logic [COND_W-1:0] condCode,
  output logic [DATA_W-1:0] accOut,
  output logic [DATA_W-1:0] regOut,
  output logic [FLAG_W-1:0] flagsOut,
  output logic              condTrue
);

  aluCtrl_t  ctrl;
  aluFlags_t flagsQ;

  accum_alu_ctrl u_ctrl (
    .opValid (opValid),
    .opCode  (opCode),
    .ctrl    (ctrl)
  );

  accum_alu_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .operand (operand),
    .accQ    (accOut),
    .regQ    (regOut),
    .flagsQ  (flagsQ)
  );

  accum_alu_cond u_cond (
    .flags    (flagsQ),
    .condCode (condCode),
    .condTrue (condTrue)
  );

  assign flagsOut = flagsQ;

endmodule

// File: rtl/accum_alu_chk.sv
module accum_alu_chk
  import accum_alu_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [OP_W-1:0]   opCode,
  input logic [COND_W-1:0] condCode,
  input logic [DATA_W-1:0] accOut,
  input logic [DATA_W-1:0] regOut,
  input logic [FLAG_W-1:0] flagsOut,
  input logic              condTrue
);

  assert_cma_invert_R5: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_CMA) |=> (accOut == ~$past(accOut)) && (flagsOut == $past(flagsOut)));

  assert_cmc_toggle_R6: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_CMC) |=> (flagsOut[FLAG_CY] != $past(flagsOut[FLAG_CY]))
      && (flagsOut[FLAG_W-1:1] == $past(flagsOut[FLAG_W-1:1])) && $stable(accOut));

  assert_step_keeps_carry_R7: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (opCode == OP_INCA || opCode == OP_DECA || opCode == OP_INCR || opCode == OP_DECR))
      |=> (flagsOut[FLAG_CY] == $past(flagsOut[FLAG_CY])));

  assert_logic_clears_R4: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (opCode == OP_AND || opCode == OP_OR || opCode == OP_XOR))
      |=> (!flagsOut[FLAG_CY] && !flagsOut[FLAG_AUX]));

  assert_zero_matches_R8: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (opCode <= OP_XOR || opCode == OP_INCA || opCode == OP_DECA || opCode == OP_DAA))
      |=> (flagsOut[FLAG_ZER] == (accOut == '0)));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> ($stable(accOut) && $stable(regOut) && $stable(flagsOut)));

  assert_always_taken_R10: assert property (@(posedge clk) disable iff (!rstN)
    (condCode == CC_ALWAYS) |-> condTrue);

endmodule

bind accum_alu accum_alu_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .opValid  (opValid),
  .opCode   (opCode),
  .condCode (condCode),
  .accOut   (accOut),
  .regOut   (regOut),
  .flagsOut (flagsOut),
  .condTrue (condTrue)
);

// File: tb/tb_accum_alu.sv
`timescale 1ns/1ps
module tb_accum_alu;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       opValid = 1'b0;
  logic [3:0] opCode = 4'd15;
  logic [7:0] operand = 8'd0;
  logic [3:0] condCode = 4'd0;
  logic [7:0] accOut, regOut;
  logic [4:0] flagsOut;
  logic       condTrue;

  int checks = 0;
  int fails = 0;

  int mA = 0, mR = 0;
  bit mS = 0, mZ = 0, mAC = 0, mP = 0, mC = 0;

  always #5 clk = ~clk;

  accum_alu dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .operand(operand),
    .condCode(condCode), .accOut(accOut), .regOut(regOut), .flagsOut(flagsOut),
    .condTrue(condTrue)
  );

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish, got hung expected done");
    summary();
  end

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic int expFlags();
    return {27'd0, mS, mZ, mAC, mP, mC};
  endfunction

  task automatic setSzp(int v);
    mS = v[7];
    mZ = (v == 0);
    mP = ($countones(v[7:0]) % 2) == 0;
  endtask

  task automatic model(int op, int v);
    int s, c, lo, t;
    bit lf, hf;
    case (op)
      0, 1: begin
        c = (op == 1) ? int'(mC) : 0;
        s = mA + v + c;
        mAC = ((mA & 15) + (v & 15) + c) > 15;
        mC = s > 255; mA = s & 255; setSzp(mA);
      end
      2, 3: begin
        c = (op == 3) ? int'(mC) : 0;
        s = mA - v - c;
        mAC = ((mA & 15) - (v & 15) - c) < 0;
        mC = s < 0; mA = s & 255; setSzp(mA);
      end
      4: begin mA = mA & v; mC = 0; mAC = 0; setSzp(mA); end
      5: begin mA = mA | v; mC = 0; mAC = 0; setSzp(mA); end
      6: begin mA = mA ^ v; mC = 0; mAC = 0; setSzp(mA); end
      7: mA = (~mA) & 255;
      8: mC = !mC;
      9:  begin mAC = (mA & 15) == 15; mA = (mA + 1) & 255; setSzp(mA); end
      10: begin mAC = (mA & 15) == 0;  mA = (mA - 1) & 255; setSzp(mA); end
      11: begin mAC = (v & 15) == 15;  mR = (v + 1) & 255;  setSzp(mR); end
      12: begin mAC = (v & 15) == 0;   mR = (v - 1) & 255;  setSzp(mR); end
      13: begin
        lo = mA & 15;
        lf = (lo > 9) || mAC;
        t = mA + (lf ? 6 : 0);
        mAC = lf && (lo + 6 > 15);
        hf = (((t >> 4) & 15) > 9) || (t > 255) || mC;
        mA = (t + (hf ? 96 : 0)) & 255;
        mC = hf;
        setSzp(mA);
      end
      14: mA = v;
      default: ;
    endcase
  endtask

  // One command per clock; inputs change and outputs are sampled on falling edges.
  task automatic step(int op, int v, string tag, bit valid = 1'b1);
    opValid = valid;
    opCode = op[3:0];
    operand = v[7:0];
    @(posedge clk);
    @(negedge clk);
    opValid = 1'b0;
    if (valid) model(op, v);
    check({tag, " acc"}, int'(accOut), mA);
    check({tag, " reg"}, int'(regOut), mR);
    check({tag, " flags"}, int'(flagsOut), expFlags());
  endtask

  task automatic setCarry(bit want);
    if (mC != want) step(8, 0, "R6 toggle");
  endtask

  task automatic checkConds(string tag);
    bit e;
    for (int k = 0; k < 16; k++) begin
      condCode = k[3:0];
      #1;
      case (k)
        0: e = 1'b1;
        1: e = mC;
        2: e = !mC;
        3: e = mZ;
        4: e = !mZ;
        5: e = mP;
        6: e = !mP;
        7: e = !mS;
        8: e = mS;
        default: e = 1'b0;
      endcase
      check(tag, int'(condTrue), int'(e));
    end
    condCode = 4'd0;
  endtask

  function automatic int toBcd(int d);
    return ((d / 10) << 4) | (d % 10);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset acc", int'(accOut), 0);
    check("R1 reset reg", int'(regOut), 0);
    check("R1 reset flags", int'(flagsOut), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", int'(flagsOut), 0);

    // R2 / R3: add, add with carry, subtract, subtract with borrow
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b += 17) begin
        step(14, a, "R11 load");
        step(0, b, "R2 add");
        for (int c = 0; c < 2; c++) begin
          step(14, a, "R11 load");
          setCarry(c[0]);
          step(1, b, "R2 add carry");
        end
        step(14, a, "R11 load");
        step(2, b, "R3 sub");
        for (int c = 0; c < 2; c++) begin
          step(14, a, "R11 load");
          setCarry(c[0]);
          step(3, b, "R3 sub borrow");
        end
      end
    end

    // R4: logic ops, entered with carry set so the clearing shows
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b += 17) begin
        for (int op = 4; op <= 6; op++) begin
          step(14, a, "R11 load");
          setCarry(1'b1);
          step(op, b, "R4 logic");
        end
      end
    end

    // R5 / R6 / R7 / R10 / R11 over every accumulator value
    for (int a = 0; a < 256; a++) begin
      step(14, a, "R11 load");
      step(7, 0, "R5 complement");
      step(8, 0, "R6 toggle carry");
      step(9, 0, "R7 inc acc");
      step(10, 0, "R7 dec acc");
      step(11, a, "R7 inc reg");
      step(12, a, "R7 dec reg");
      step(0, 99, "R11 idle", 1'b0);
      step(15, a, "R11 nop");
      step(14, a, "R11 load");
      step(5, 0, "R8 or zero");
      checkConds("R10 cond carry clear");
      step(8, 0, "R6 toggle carry");
      checkConds("R10 cond carry set");
    end

    // R9: every pair of two-digit BCD operands
    for (int x = 0; x < 100; x++) begin
      for (int y = 0; y < 100; y++) begin
        step(14, toBcd(x), "R11 load");
        step(0, toBcd(y), "R2 add bcd");
        step(13, 0, "R9 adjust");
        check("R9 decimal sum", int'(accOut), toBcd((x + y) % 100));
        check("R9 decimal carry", int'(flagsOut[0]), int'((x + y) >= 100));
      end
    end

    summary();
  end

endmodule